// File: doc/BRIEF.md
# Access-Split Direct-Mapped Translation Cache

This block caches virtual-page to physical-page translations in six small direct-mapped arrays. There is one array for each pairing of access kind (read, write, instruction fetch) with privilege (user, kernel). A requester presents a virtual address, an access kind and a privilege bit. The block uses the access kind and privilege bit to pick one array, then indexes that array with the low bits of the virtual page number and compares the stored tag. Translations are only ever placed in the array whose access kind and privilege match the miss that caused them. A valid, matching entry therefore proves both the mapping and the right to make that access, so the hit path contains no separate permission logic.

On a miss the block asks an external page walker for the frame. While the walk is outstanding, `req_ready` stays low and new lookups stall. If the walker returns a frame, the block writes it only into the array that missed and answers the requester as if the lookup had hit. If the walker reports a fault, the block installs nothing and passes the fault on to the requester. A single-cycle flush clears every entry in all six arrays.

The controller has two states. `ST_LOOKUP` accepts requests, and `ST_WALK` waits for the walker. Transition T_MISS goes from `ST_LOOKUP` to `ST_WALK` when an accepted lookup misses. Transition T_DONE goes from `ST_WALK` back to `ST_LOOKUP` when the walker responds, whether it returns a frame or a fault. When an accepted lookup hits, the controller stays in `ST_LOOKUP` (T_HIT).

Top module: `split_tlb`

## Requirements
- R1: After reset, every entry is invalid, `req_ready` is 1, `rsp_valid` is 0 and `walk_req_valid` is 0.
- R2: The virtual page number is `req_vaddr[31:12]`. Its bits [3:0] select one of 16 lines, and bits [19:4] are the tag. Two page numbers that share bits [3:0] evict each other within the same array and leave the other lines alone.
- R3: The array is chosen by `req_kind` and `req_kernel`. The `req_kind` encodings are 0 = read, 1 = write, 2 = fetch, and 3 is handled as fetch. A translation installed in one array is never seen by a lookup that selects a different array.
- R4: When an accepted lookup hits a valid line with a matching tag, `rsp_valid` is 1 with `rsp_fault` 0 in the cycle after acceptance, and no walk is requested.
- R5: `rsp_paddr` is the cached or walked 20-bit frame number in bits [31:12], with `req_vaddr[11:0]` carried unchanged into bits [11:0].
- R6: When an accepted lookup misses, `walk_req_valid` is 1 from the next cycle. It carries the page number, kind and privilege of that lookup, and these stay stable until `walk_rsp_valid` is seen.
- R7: A walk response with `walk_rsp_fault` 0 gives `rsp_valid` and the translated address in the next cycle. It installs the frame into the missing array only, so a repeat of the same lookup then hits.
- R8: A walk response with `walk_rsp_fault` 1 gives `rsp_valid` with `rsp_fault` 1 in the next cycle and installs nothing, so a repeat of the same lookup walks again.
- R9: `req_ready` is 0 from the cycle after a miss is accepted until the walk response has been taken, so no lookup is accepted in between.
- R10: A one-cycle `flush` invalidates every line of all six arrays and holds `req_ready` at 0 in that cycle. A walk response taken in a flush cycle is still returned to the requester but is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines of all arrays |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_vaddr | input | 32 | Virtual address of the lookup |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 and 3 fetch |
| req_kernel | input | 1 | 1 for kernel privilege, 0 for user |
| rsp_valid | output | 1 | Lookup result valid for one cycle |
| rsp_fault | output | 1 | Result is a page fault |
| rsp_paddr | output | 32 | Translated physical address |
| walk_req_valid | output | 1 | Walk requested |
| walk_req_vpn | output | 20 | Page number to walk |
| walk_req_kind | output | 2 | Access kind of the missing lookup |
| walk_req_kernel | output | 1 | Privilege of the missing lookup |
| walk_rsp_valid | input | 1 | Walker response present |
| walk_rsp_fault | input | 1 | Walker found no permitted mapping |
| walk_rsp_pfn | input | 20 | Frame number from the walker |

## Verification
A hit is due one cycle after acceptance, so the bench drives on the falling edge and reads `rsp_valid` at the very next falling edge. At that same edge it expects either the response or `walk_req_valid` and nothing else. A missing lookup's result is due one cycle after the walk response is taken: the bench raises `walk_rsp_valid` for exactly one falling-edge-to-falling-edge window and reads the answer at the following falling edge. While it delays the walker by several cycles, it checks at every falling edge that `req_ready` is low and that the walk fields are unchanged. To see whether a line is present, the bench observes whether a walk request appears at the first falling edge after acceptance.

// File: rtl/tlbsplit_pkg.sv
package tlbsplit_pkg;

    localparam int NUM_ARRAYS = 6;
    localparam int SEL_W      = 3;

    typedef enum logic {
        ST_LOOKUP = 1'b0,
        ST_WALK   = 1'b1
    } ctrl_state_e;

    // Kind 0 read, 1 write, 2 and 3 fetch; kernel arrays follow user arrays.
    function automatic logic [SEL_W-1:0] arr_sel(input logic [1:0] kind,
                                                 input logic       kernel);
        logic [SEL_W-1:0] base;
        case (kind)
            2'd0:    base = 3'd0;
            2'd1:    base = 3'd1;
            default: base = 3'd2;
        endcase
        return kernel ? base + 3'd3 : base;
    endfunction

endpackage

// File: rtl/tlbsplit_array.sv
module tlbsplit_array #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 16,
    parameter int PFN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PFN_W-1:0] wr_pfn
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            pfn_q[wr_idx] <= wr_pfn;
        end
    end

    always_comb begin
        lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_pfn = pfn_q[lk_idx];
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0)); // R10
    AST_FILL_VALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> valid_q[$past(wr_idx)]); // R7

endmodule

// File: rtl/tlbsplit_ctrl.sv
module tlbsplit_ctrl
    import tlbsplit_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PFN_W     = 20,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PA_W     = PFN_W + PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic             req_kernel,
    output logic             req_ready,
    input  logic             lk_hit,
    input  logic [PFN_W-1:0] lk_pfn,
    output logic             walk_req_valid,
    output logic [VPN_W-1:0] walk_req_vpn,
    output logic [1:0]       walk_req_kind,
    output logic             walk_req_kernel,
    input  logic             walk_rsp_valid,
    input  logic             walk_rsp_fault,
    input  logic [PFN_W-1:0] walk_rsp_pfn,
    output logic             fill_en,
    output logic [SEL_W-1:0] fill_sel,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [PFN_W-1:0] fill_pfn,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr
);
    ctrl_state_e state_q, state_d;

    logic [VPN_W-1:0]     vpn_q;
    logic [PAGE_BITS-1:0] off_q;
    logic [1:0]           kind_q;
    logic                 kern_q;
    logic                 accept;
    logic                 walk_done;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    // next state: T_HIT stays, T_MISS enters walk, T_DONE leaves it
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP: if (accept && !lk_hit) state_d = ST_WALK;
            ST_WALK:   if (walk_rsp_valid)    state_d = ST_LOOKUP;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        req_ready       = (state_q == ST_LOOKUP) && !flush;
        accept          = req_valid && req_ready;
        walk_req_valid  = (state_q == ST_WALK);
        walk_done       = (state_q == ST_WALK) && walk_rsp_valid;
        walk_req_vpn    = vpn_q;
        walk_req_kind   = kind_q;
        walk_req_kernel = kern_q;
        fill_en         = walk_done && !walk_rsp_fault;
        fill_sel        = arr_sel(kind_q, kern_q);
        fill_vpn        = vpn_q;
        fill_pfn        = walk_rsp_pfn;
    end

    // capture of the missing request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            off_q  <= '0;
            kind_q <= '0;
            kern_q <= 1'b0;
        end else if (accept) begin
            vpn_q  <= req_vaddr[VA_W-1:PAGE_BITS];
            off_q  <= req_vaddr[PAGE_BITS-1:0];
            kind_q <= req_kind;
            kern_q <= req_kernel;
        end
    end

    // registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            if (accept && lk_hit) begin
                rsp_valid <= 1'b1;
                rsp_paddr <= {lk_pfn, req_vaddr[PAGE_BITS-1:0]};
            end else if (walk_done) begin
                rsp_valid <= 1'b1;
                rsp_fault <= walk_rsp_fault;
                rsp_paddr <= walk_rsp_fault ? '0 : {walk_rsp_pfn, off_q};
            end
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WALK) |-> !req_ready); // R9
    AST_MISS_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !lk_hit) |=> walk_req_valid); // R6
    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !walk_rsp_valid) |=> (walk_req_valid && $stable(walk_req_vpn))); // R6
    AST_HIT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_hit) |=> (rsp_valid && !rsp_fault)); // R4
    AST_FAULT_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid); // R8

endmodule

// File: rtl/split_tlb.sv
module split_tlb
    import tlbsplit_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PFN_W     = 20,
    parameter int IDX_W     = 4,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int TAG_W    = VPN_W - IDX_W,
    localparam int PA_W     = PFN_W + PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic             req_kernel,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             walk_req_valid,
    output logic [VPN_W-1:0] walk_req_vpn,
    output logic [1:0]       walk_req_kind,
    output logic             walk_req_kernel,
    input  logic             walk_rsp_valid,
    input  logic             walk_rsp_fault,
    input  logic [PFN_W-1:0] walk_rsp_pfn
);
    logic [SEL_W-1:0]      lk_sel;
    logic [IDX_W-1:0]      lk_idx;
    logic [TAG_W-1:0]      lk_tag;
    logic                  lk_hit;
    logic [PFN_W-1:0]      lk_pfn;
    logic [NUM_ARRAYS-1:0] hit_vec;
    logic [PFN_W-1:0]      pfn_vec [NUM_ARRAYS];
    logic [NUM_ARRAYS-1:0] wr_vec;
    logic                  fill_en;
    logic [SEL_W-1:0]      fill_sel;
    logic [VPN_W-1:0]      fill_vpn;
    logic [PFN_W-1:0]      fill_pfn;

    always_comb begin
        lk_sel = arr_sel(req_kind, req_kernel);
        lk_idx = req_vaddr[PAGE_BITS +: IDX_W];
        lk_tag = req_vaddr[VA_W-1 -: TAG_W];
        lk_hit = 1'b0;
        lk_pfn = '0;
        for (int a = 0; a < NUM_ARRAYS; a++) begin
            if (lk_sel == SEL_W'(a)) begin
                lk_hit = hit_vec[a];
                lk_pfn = pfn_vec[a];
            end
        end
    end

    for (genvar g = 0; g < NUM_ARRAYS; g++) begin : g_arr
        assign wr_vec[g] = fill_en && (fill_sel == SEL_W'(g));

        tlbsplit_array #(
            .IDX_W (IDX_W),
            .TAG_W (TAG_W),
            .PFN_W (PFN_W)
        ) i_array (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (flush),
            .lk_idx (lk_idx),
            .lk_tag (lk_tag),
            .lk_hit (hit_vec[g]),
            .lk_pfn (pfn_vec[g]),
            .wr_en  (wr_vec[g]),
            .wr_idx (fill_vpn[IDX_W-1:0]),
            .wr_tag (fill_vpn[VPN_W-1 -: TAG_W]),
            .wr_pfn (fill_pfn)
        );
    end

    tlbsplit_ctrl #(
        .VA_W      (VA_W),
        .PAGE_BITS (PAGE_BITS),
        .PFN_W     (PFN_W)
    ) i_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .flush           (flush),
        .req_valid       (req_valid),
        .req_vaddr       (req_vaddr),
        .req_kind        (req_kind),
        .req_kernel      (req_kernel),
        .req_ready       (req_ready),
        .lk_hit          (lk_hit),
        .lk_pfn          (lk_pfn),
        .walk_req_valid  (walk_req_valid),
        .walk_req_vpn    (walk_req_vpn),
        .walk_req_kind   (walk_req_kind),
        .walk_req_kernel (walk_req_kernel),
        .walk_rsp_valid  (walk_rsp_valid),
        .walk_rsp_fault  (walk_rsp_fault),
        .walk_rsp_pfn    (walk_rsp_pfn),
        .fill_en         (fill_en),
        .fill_sel        (fill_sel),
        .fill_vpn        (fill_vpn),
        .fill_pfn        (fill_pfn),
        .rsp_valid       (rsp_valid),
        .rsp_fault       (rsp_fault),
        .rsp_paddr       (rsp_paddr)
    );

    AST_FILL_NEEDS_GOOD_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_vec) |-> (walk_rsp_valid && !walk_rsp_fault)); // R8
    AST_FILL_MATCHES_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_vec) |-> (arr_sel(walk_req_kind, walk_req_kernel) == fill_sel)); // R3

endmodule

// File: tb/test_split_tlb.sv
module test_split_tlb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_kernel = 1'b0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_paddr;
    logic        walk_req_valid;
    logic [19:0] walk_req_vpn;
    logic [1:0]  walk_req_kind;
    logic        walk_req_kernel;
    logic        walk_rsp_valid = 1'b0;
    logic        walk_rsp_fault = 1'b0;
    logic [19:0] walk_rsp_pfn = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    split_tlb i_split_tlb (
        .clk             (clk),
        .rst_n           (rst_n),
        .flush           (flush),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_vaddr       (req_vaddr),
        .req_kind        (req_kind),
        .req_kernel      (req_kernel),
        .rsp_valid       (rsp_valid),
        .rsp_fault       (rsp_fault),
        .rsp_paddr       (rsp_paddr),
        .walk_req_valid  (walk_req_valid),
        .walk_req_vpn    (walk_req_vpn),
        .walk_req_kind   (walk_req_kind),
        .walk_req_kernel (walk_req_kernel),
        .walk_rsp_valid  (walk_rsp_valid),
        .walk_rsp_fault  (walk_rsp_fault),
        .walk_rsp_pfn    (walk_rsp_pfn)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] model_pfn(input logic [19:0] vpn,
                                              input logic [1:0] kind,
                                              input logic kern);
        logic [31:0] v;
        v = {12'd0, vpn} * 32'd7 + {29'd0, kind, kern} * 32'd4099 + 32'h5A5;
        return v[19:0];
    endfunction

    // One lookup, answering any walk; returns what was observed.
    task automatic access(input logic [31:0] va, input logic [1:0] kind,
                          input logic kern, input logic wfault, input int wdelay,
                          input logic flush_at_rsp, output logic saw_walk,
                          output logic got_fault, output logic [31:0] pa);
        int n;
        n = 0;
        saw_walk = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready before lookup", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_kernel = kern;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && n < 50) begin
            if (walk_req_valid) begin
                saw_walk = 1'b1;
                chk(walk_req_vpn == va[31:12], "R6 walk vpn", 64'(walk_req_vpn), 64'(va[31:12]));
                chk(walk_req_kind == kind && walk_req_kernel == kern, "R6 walk kind/priv",
                    64'({walk_req_kind, walk_req_kernel}), 64'({kind, kern}));
                chk(req_ready == 1'b0, "R9 ready low in walk", 64'(req_ready), 64'd0);
                for (int d = 0; d < wdelay; d++) begin
                    @(negedge clk);
                    chk(walk_req_valid && walk_req_vpn == va[31:12], "R6 walk held",
                        64'({walk_req_valid, walk_req_vpn}), 64'({1'b1, va[31:12]}));
                    chk(req_ready == 1'b0, "R9 ready low while stalled", 64'(req_ready), 64'd0);
                end
                walk_rsp_valid = 1'b1;
                walk_rsp_fault = wfault;
                walk_rsp_pfn   = model_pfn(va[31:12], kind, kern);
                flush          = flush_at_rsp;
                @(negedge clk);
                walk_rsp_valid = 1'b0;
                walk_rsp_fault = 1'b0;
                flush          = 1'b0;
            end else begin
                @(negedge clk);
                n++;
            end
        end
        chk(rsp_valid == 1'b1, "R4 response arrived", 64'(rsp_valid), 64'd1);
        got_fault = rsp_fault;
        pa        = rsp_paddr;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R4 response one cycle", 64'(rsp_valid), 64'd0);
    endtask

    function automatic logic [31:0] mk_va(input logic [19:0] vpn, input logic [11:0] off);
        return {vpn, off};
    endfunction

    // Lookup expecting success; checks walk presence and address.
    task automatic expect_ok(input logic [19:0] vpn, input logic [11:0] off,
                             input logic [1:0] kind, input logic kern,
                             input logic exp_walk, input string tag);
        logic sw, gf;
        logic [31:0] pa;
        logic [1:0] mk;
        mk = (kind == 2'd3) ? 2'd2 : kind;
        access(mk_va(vpn, off), kind, kern, 1'b0, 0, 1'b0, sw, gf, pa);
        chk(sw == exp_walk, {tag, " walk presence"}, 64'(sw), 64'(exp_walk));
        chk(gf == 1'b0, {tag, " no fault"}, 64'(gf), 64'd0);
        chk(pa == {model_pfn(vpn, mk, kern), off}, {"R5 ", tag, " paddr"}, 64'(pa),
            64'({model_pfn(vpn, mk, kern), off}));
    endtask

    initial begin : watchdog
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic sw, gf;
        logic [31:0] pa;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && walk_req_valid == 1'b0, "R1 reset outputs",
            64'({req_ready, rsp_valid, walk_req_valid}), 64'b100);

        // R1: nothing cached after reset
        expect_ok(20'd7, 12'h0, 2'd0, 1'b0, 1'b1, "R1 empty after reset");

        // R7 fill sweep over all six arrays and all 16 lines
        for (int a = 0; a < 6; a++)
            for (int i = 0; i < 16; i++)
                expect_ok(20'(i + 16 * (a + 1)), 12'((i * 273 + a * 37) & 12'hFFF),
                          2'(a % 3), 1'(a / 3), 1'b1, "R7 fill");

        // R4 / R2 hit sweep
        for (int a = 0; a < 6; a++)
            for (int i = 0; i < 16; i++)
                expect_ok(20'(i + 16 * (a + 1)), 12'((i * 91 + a * 5 + 1) & 12'hFFF),
                          2'(a % 3), 1'(a / 3), 1'b0, "R4 hit");

        // R3: read-user line not visible to write-user or read-kernel
        expect_ok(20'd16, 12'h123, 2'd1, 1'b0, 1'b1, "R3 write array separate");
        expect_ok(20'd16, 12'h456, 2'd0, 1'b1, 1'b1, "R3 kernel array separate");
        // R3: kind 3 selects fetch-user array (vpn 48 filled there)
        expect_ok(20'd48, 12'hABC, 2'd3, 1'b0, 1'b0, "R3 kind3 is fetch");

        // R2: aliasing lines evict each other, neighbours survive
        expect_ok(20'd21 + 20'd640, 12'h010, 2'd0, 1'b0, 1'b1, "R2 alias miss");
        expect_ok(20'd21, 12'h020, 2'd0, 1'b0, 1'b1, "R2 evicted");
        expect_ok(20'd22, 12'h030, 2'd0, 1'b0, 1'b0, "R2 other line kept");

        // R8: fault installs nothing
        access(mk_va(20'd1000, 12'h777), 2'd0, 1'b1, 1'b1, 0, 1'b0, sw, gf, pa);
        chk(sw == 1'b1 && gf == 1'b1, "R8 fault returned", 64'({sw, gf}), 64'b11);
        expect_ok(20'd1000, 12'h777, 2'd0, 1'b1, 1'b1, "R8 no install after fault");
        expect_ok(20'd1000, 12'h001, 2'd0, 1'b1, 1'b0, "R8 later hit");

        // R9: slow walker stalls lookups
        access(mk_va(20'd3000, 12'hFFF), 2'd2, 1'b1, 1'b0, 5, 1'b0, sw, gf, pa);
        chk(sw && !gf && pa == {model_pfn(20'd3000, 2'd2, 1'b1), 12'hFFF}, "R9 delayed walk result",
            64'(pa), 64'({model_pfn(20'd3000, 2'd2, 1'b1), 12'hFFF}));

        // R10: flush clears everything
        @(negedge clk);
        flush = 1'b1;
        #1;
        chk(req_ready == 1'b0, "R10 ready low in flush", 64'(req_ready), 64'd0);
        @(negedge clk);
        flush = 1'b0;
        expect_ok(20'd22, 12'h040, 2'd0, 1'b0, 1'b1, "R10 read line flushed");
        expect_ok(20'd3000, 12'h050, 2'd2, 1'b1, 1'b1, "R10 fetch line flushed");

        // R10: walk response taken during flush is returned but not kept
        access(mk_va(20'd2000, 12'h0AB), 2'd1, 1'b1, 1'b0, 0, 1'b1, sw, gf, pa);
        chk(sw && !gf && pa == {model_pfn(20'd2000, 2'd1, 1'b1), 12'h0AB}, "R10 flush-time result",
            64'(pa), 64'({model_pfn(20'd2000, 2'd1, 1'b1), 12'h0AB}));
        expect_ok(20'd2000, 12'h0CD, 2'd1, 1'b1, 1'b1, "R10 flush-time not installed");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule